// File: doc/BRIEF.md
# Dual-Address DMA Channel Sequencer

This block is one direct-memory-access channel. Software loads a source address, a destination address, a byte count and a few transfer settings with a single load pulse. After that, each request on `dreq` makes the channel copy data on its own. Every data unit is first fetched from the source over a read channel and then stored at the destination over a write channel. Both channels use a request/ready handshake: a transfer completes in any cycle where request and ready are both high.

Each transfer is built from units of 1 to 16 bytes. A fixed number of units, a power of two from 1 to 128, forms an operand. The transfer condition sets how much one request moves: exactly one operand, one operand per request with one extra request held back, or everything up to an empty count. Timing mode is a separate choice. In cycle-stealing mode the channel frees the bus for a cycle after every unit. In pipelined mode the next read runs in parallel with the current write.

After each unit, both addresses step by the unit size unless their increment bit is off. The remaining byte count also drops by the unit size after each write. When the count runs out, `done` rises and the channel stays quiet until it is loaded again.

Top module: `dma_chan_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `rd_req`, `wr_req`, `busy` and `done` are all low.
- R2: `cfg_size` encodes the unit size: 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16 bytes, and 5 to 7 act as 4. The same code is returned on `unit_size`. Addresses advance by this many bytes per unit, and the remaining count never grows except on a load.
- R3: `cfg_oplen` value n makes one operand 2^n units long (1 to 128).
- R4: With `cfg_cond` = 0 (unit mode; 3 behaves the same), a request accepted while idle moves one operand. A request that arrives while that operand is running is dropped.
- R5: With `cfg_cond` = 1 (sequential mode), each request moves one operand. One request that arrives while an operand is running is kept, and the next operand starts as soon as the current one finishes.
- R6: With `cfg_cond` = 2 (non-stop mode), a single request moves the whole count, one operand after another.
- R7: Each write carries the data returned by the matching read. Writes come in the same order as the reads.
- R8: With `cfg_pipe` = 0 (cycle stealing), no read is requested in the cycle after a completed write. With ready held high, consecutive writes of one operand are exactly three cycles apart.
- R9: With `cfg_pipe` = 1 (pipelined), a read may complete in the same cycle as a write. With ready held high, writes inside one operand come one per clock.
- R10: With `cfg_src_inc` or `cfg_dst_inc` low, that address stays at its loaded value for the whole transfer.
- R11: `done` rises once the count reaches zero (or at once if 0 is loaded). It then holds, with no request issued even if `dreq` pulses, until the next `cfg_load`, which clears it.
- R12: A read or write request that is not yet accepted stays asserted in the next cycle, with its address and write data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_load | input | 1 | Load all settings and re-arm the channel |
| cfg_src | input | 32 | Source start address |
| cfg_dst | input | 32 | Destination start address |
| cfg_count | input | 26 | Byte count |
| cfg_size | input | 3 | Unit size code |
| cfg_oplen | input | 3 | log2 of units per operand |
| cfg_cond | input | 2 | Transfer condition |
| cfg_pipe | input | 1 | 1 = pipelined, 0 = cycle stealing |
| cfg_src_inc | input | 1 | Step source address |
| cfg_dst_inc | input | 1 | Step destination address |
| dreq | input | 1 | Transfer request, one per high cycle |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read address |
| rd_ready | input | 1 | Read accepted, data valid |
| rd_data | input | 128 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 128 | Write data |
| wr_ready | input | 1 | Write accepted |
| unit_size | output | 3 | Latched unit size code |
| busy | output | 1 | An operand is in progress |
| done | output | 1 | Count exhausted |

## Verification
The hardest state to reach from the ports is a second request arriving in the middle of a running operand. The channel must keep it in sequential mode and drop it in unit mode. The stimulus pulses `dreq` a few cycles after an accepted request, while `busy` is high. It then counts how many writes follow with no further request. A pipelined run with pseudo-random ready on both channels fills the two-entry data buffer. This forces requests to wait, so handshake holding is tested while reads and writes overlap.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    COND_UNIT    = 2'd0,
    COND_SEQ     = 2'd1,
    COND_NONSTOP = 2'd2,
    COND_RSVD    = 2'd3
  } xfer_cond_e;

  localparam int SIZE_W = 3;
  localparam int OPU_W  = 8;
  localparam int UB_W   = 5;

  // bytes per unit for a size code; codes above 4 clamp to 16 bytes
  function automatic logic [UB_W-1:0] unit_bytes(input logic [SIZE_W-1:0] code);
    logic [UB_W-1:0] r;
    case (code)
      3'd0:    r = 5'd1;
      3'd1:    r = 5'd2;
      3'd2:    r = 5'd4;
      3'd3:    r = 5'd8;
      default: r = 5'd16;
    endcase
    return r;
  endfunction

  // units per operand: 2^oplen
  function automatic logic [OPU_W-1:0] op_units(input logic [2:0] oplen);
    return OPU_W'(1) << oplen;
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              fire,
  input  logic              inc_en,
  input  logic [STEP_W-1:0] step,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_q;

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input logic en,
                                                  input logic [STEP_W-1:0] s);
    return en ? a + ADDR_W'(s) : a;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= load_val;
    else if (fire) addr_q <= next_addr(addr_q, inc_en, step);
  end

  assign addr = addr_q;

endmodule

// File: rtl/dma_xfer_buf.sv
module dma_xfer_buf #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [1:0]        cnt
);

  localparam int DEPTH = 2;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              wp_q, rp_q;
  logic [1:0]        cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= 1'b0;
      rp_q  <= 1'b0;
      cnt_q <= '0;
    end else if (flush) begin
      wp_q  <= 1'b0;
      rp_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= ~wp_q;
      if (pop)  rp_q <= ~rp_q;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 2'd1;
        2'b01:   cnt_q <= cnt_q - 2'd1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wp_q == e[0])) mem_q[e] <= din;
    end
  end

  assign head = mem_q[rp_q];
  assign cnt  = cnt_q;

endmodule

// File: rtl/dma_op_ctrl.sv
module dma_op_ctrl
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  xfer_cond_e       cond,
  input  logic             pipe,
  input  logic             dreq,
  input  logic             rd_ready,
  input  logic [1:0]       buf_cnt,
  input  logic             wr_fire,
  input  logic [UB_W-1:0]  ub,
  input  logic [OPU_W-1:0] units,
  output logic             rd_req,
  output logic             rd_fire,
  output logic             in_op,
  output logic             op_end,
  output logic             done,
  output logic [CNT_W-1:0] bytes_left
);

  logic             in_op_q, pend_q, gap_q, done_q, armed_q;
  logic [OPU_W-1:0] op_left_q;
  logic [CNT_W-1:0] rd_left_q, left_q;
  logic             rd_gate, req_seen, restart;

  // remaining count after one unit, floored at zero
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c,
                                                 input logic [UB_W-1:0] s);
    return (c > CNT_W'(s)) ? c - CNT_W'(s) : '0;
  endfunction

  always_comb begin
    rd_gate  = pipe ? (buf_cnt != 2'd2) : ((buf_cnt == 2'd0) && !gap_q);
    rd_req   = in_op_q && (op_left_q != '0) && (rd_left_q != '0) && rd_gate;
    rd_fire  = rd_req && rd_ready;
    op_end   = in_op_q && ((op_left_q == '0) || (rd_left_q == '0)) && (buf_cnt == 2'd0);
    req_seen = dreq || pend_q;
    restart  = (cond == COND_NONSTOP) || ((cond == COND_SEQ) && req_seen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_op_q   <= 1'b0;
      pend_q    <= 1'b0;
      gap_q     <= 1'b0;
      done_q    <= 1'b0;
      armed_q   <= 1'b0;
      op_left_q <= '0;
      rd_left_q <= '0;
      left_q    <= '0;
    end else if (load) begin
      in_op_q   <= 1'b0;
      pend_q    <= 1'b0;
      gap_q     <= 1'b0;
      op_left_q <= '0;
      rd_left_q <= load_cnt;
      left_q    <= load_cnt;
      done_q    <= (load_cnt == '0);
      armed_q   <= (load_cnt != '0);
    end else begin
      gap_q <= wr_fire && !pipe;
      if (rd_fire) begin
        rd_left_q <= step_down(rd_left_q, ub);
        op_left_q <= op_left_q - OPU_W'(1);
      end
      if (wr_fire) left_q <= step_down(left_q, ub);

      if (op_end) begin
        if (left_q == '0) begin
          in_op_q <= 1'b0;
          done_q  <= 1'b1;
          armed_q <= 1'b0;
          pend_q  <= 1'b0;
        end else if (restart) begin
          op_left_q <= units;
          pend_q    <= 1'b0;
        end else begin
          in_op_q <= 1'b0;
        end
      end else if (!in_op_q && armed_q && req_seen) begin
        in_op_q   <= 1'b1;
        op_left_q <= units;
        pend_q    <= 1'b0;
      end else if (in_op_q && dreq && (cond == COND_SEQ)) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign in_op      = in_op_q;
  assign done       = done_q;
  assign bytes_left = left_q;

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 26,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [2:0]        cfg_size,
  input  logic [2:0]        cfg_oplen,
  input  logic [1:0]        cfg_cond,
  input  logic              cfg_pipe,
  input  logic              cfg_src_inc,
  input  logic              cfg_dst_inc,
  input  logic              dreq,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ready,
  output logic [2:0]        unit_size,
  output logic              busy,
  output logic              done
);

  localparam int N_PTR = 2;

  // latched settings
  logic [SIZE_W-1:0] size_q;
  logic [2:0]        oplen_q;
  xfer_cond_e        cond_q;
  logic              pipe_q, sinc_q, dinc_q;

  // internal events, named for the checker
  logic              rd_fire, wr_fire, op_end, in_op;
  logic [UB_W-1:0]   ub;
  logic [OPU_W-1:0]  units;
  logic [1:0]        buf_cnt;
  logic [CNT_W-1:0]  bytes_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q  <= '0;
      oplen_q <= '0;
      cond_q  <= COND_UNIT;
      pipe_q  <= 1'b0;
      sinc_q  <= 1'b0;
      dinc_q  <= 1'b0;
    end else if (cfg_load) begin
      size_q  <= cfg_size;
      oplen_q <= cfg_oplen;
      cond_q  <= xfer_cond_e'(cfg_cond);
      pipe_q  <= cfg_pipe;
      sinc_q  <= cfg_src_inc;
      dinc_q  <= cfg_dst_inc;
    end
  end

  assign ub    = unit_bytes(size_q);
  assign units = op_units(oplen_q);

  dma_op_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cfg_load),
    .load_cnt   (cfg_count),
    .cond       (cond_q),
    .pipe       (pipe_q),
    .dreq       (dreq),
    .rd_ready   (rd_ready),
    .buf_cnt    (buf_cnt),
    .wr_fire    (wr_fire),
    .ub         (ub),
    .units      (units),
    .rd_req     (rd_req),
    .rd_fire    (rd_fire),
    .in_op      (in_op),
    .op_end     (op_end),
    .done       (done),
    .bytes_left (bytes_left)
  );

  dma_xfer_buf #(.DATA_W(DATA_W)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (cfg_load),
    .push  (rd_fire),
    .din   (rd_data),
    .pop   (wr_fire),
    .head  (wr_data),
    .cnt   (buf_cnt)
  );

  assign wr_req  = (buf_cnt != 2'd0);
  assign wr_fire = wr_req && wr_ready;

  // index 0 walks the source, index 1 the destination
  logic [N_PTR-1:0][ADDR_W-1:0] ptr_init, ptr_addr;
  logic [N_PTR-1:0]             ptr_fire, ptr_inc;

  assign ptr_init = {cfg_dst, cfg_src};
  assign ptr_fire = {wr_fire, rd_fire};
  assign ptr_inc  = {dinc_q, sinc_q};

  for (genvar p = 0; p < N_PTR; p++) begin : g_ptr
    dma_addr_step #(.ADDR_W(ADDR_W), .STEP_W(UB_W)) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_load),
      .load_val (ptr_init[p]),
      .fire     (ptr_fire[p]),
      .inc_en   (ptr_inc[p]),
      .step     (ub),
      .addr     (ptr_addr[p])
    );
  end

  assign rd_addr   = ptr_addr[0];
  assign wr_addr   = ptr_addr[1];
  assign unit_size = size_q;
  assign busy      = in_op;

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 26,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              rd_req,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_req,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              done,
  input logic              pipe_q,
  input logic              dinc_q,
  input logic [4:0]        ub,
  input logic [CNT_W-1:0]  bytes_left,
  input logic [1:0]        buf_cnt
);

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ready && !cfg_load |=> rd_req && $stable(rd_addr));

  p_wr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ready && !cfg_load |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  p_steal_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_q && wr_req && wr_ready && !cfg_load |=> !rd_req);

  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done && !cfg_load |=> done);

  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req && !wr_req);

  p_count_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> bytes_left <= $past(bytes_left));

  p_dst_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ready && !cfg_load |=>
      wr_addr == ($past(dinc_q) ? $past(wr_addr) + ADDR_W'($past(ub)) : $past(wr_addr)));

  p_buf_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_cnt != 2'd3);

endmodule

bind dma_chan_seq dma_chan_seq_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .rd_req     (rd_req),
  .rd_ready   (rd_ready),
  .rd_addr    (rd_addr),
  .wr_req     (wr_req),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .done       (done),
  .pipe_q     (pipe_q),
  .dinc_q     (dinc_q),
  .ub         (ub),
  .bytes_left (bytes_left),
  .buf_cnt    (buf_cnt)
);

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_load = 1'b0;
  logic [31:0]  cfg_src = '0, cfg_dst = '0;
  logic [25:0]  cfg_count = '0;
  logic [2:0]   cfg_size = '0, cfg_oplen = '0;
  logic [1:0]   cfg_cond = '0;
  logic         cfg_pipe = 1'b0, cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0;
  logic         dreq = 1'b0;
  logic         rd_req, wr_req, busy, done;
  logic [31:0]  rd_addr, wr_addr;
  logic [127:0] rd_data, wr_data;
  logic         rd_ready = 1'b1, wr_ready = 1'b1;
  logic [2:0]   unit_size;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_seq u_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count(cfg_count), .cfg_size(cfg_size), .cfg_oplen(cfg_oplen), .cfg_cond(cfg_cond),
    .cfg_pipe(cfg_pipe), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc), .dreq(dreq),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .unit_size(unit_size), .busy(busy), .done(done)
  );

  // memory model: read data is a fixed pattern of the address
  function automatic logic [127:0] pat(input logic [31:0] a);
    return {a ^ 32'h5A5A_0000, ~a, a + 32'h0000_1111, {a[15:0], a[31:16]}};
  endfunction
  assign rd_data = pat(rd_addr);

  typedef struct packed {
    logic [31:0]  addr;
    logic [127:0] data;
  } wr_item_t;

  wr_item_t exp_q[$];
  int n_checks = 0, n_errors = 0;
  int cyc = 0, n_wr = 0, last_wr = -1, min_gap = 1000, max_gap = 0;
  bit stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready = stall ? lfsr[0] : 1'b1;
    wr_ready = stall ? lfsr[3] : 1'b1;
  end

  // monitor: scoreboard pops and handshake-hold checks
  logic        prv_rd_wait = 1'b0, prv_wr_wait = 1'b0;
  logic [31:0] prv_rd_addr, prv_wr_addr;
  logic [127:0] prv_wr_data;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prv_rd_wait)
        check(rd_req && rd_addr == prv_rd_addr, "R12", "read held", {95'd0, rd_req, rd_addr},
              {95'd0, 1'b1, prv_rd_addr});
      if (prv_wr_wait)
        check(wr_req && wr_addr == prv_wr_addr && wr_data == prv_wr_data, "R12", "write held",
              wr_data, prv_wr_data);
      prv_rd_wait = rd_req && !rd_ready && !cfg_load;
      prv_wr_wait = wr_req && !wr_ready && !cfg_load;
      prv_rd_addr = rd_addr;
      prv_wr_addr = wr_addr;
      prv_wr_data = wr_data;
      if (wr_req && wr_ready) begin
        n_wr++;
        if (last_wr >= 0) begin
          if (cyc - last_wr < min_gap) min_gap = cyc - last_wr;
          if (cyc - last_wr > max_gap) max_gap = cyc - last_wr;
        end
        last_wr = cyc;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected write", {96'd0, wr_addr}, '0);
        end else begin
          wr_item_t e;
          e = exp_q.pop_front();
          check(wr_addr == e.addr, "R10", "write address", {96'd0, wr_addr}, {96'd0, e.addr});
          check(wr_data == e.data, "R7", "write data", wr_data, e.data);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_req();
    dreq = 1'b1;
    tick();
    dreq = 1'b0;
  endtask

  task automatic load(input logic [31:0] s, input logic [31:0] d, input logic [25:0] c,
                      input logic [2:0] sz, input logic [2:0] ol, input logic [1:0] cd,
                      input bit p, input bit si, input bit di);
    cfg_src = s; cfg_dst = d; cfg_count = c; cfg_size = sz; cfg_oplen = ol;
    cfg_cond = cd; cfg_pipe = p; cfg_src_inc = si; cfg_dst_inc = di;
    cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
  endtask

  // driver: push the expected writes of a run
  task automatic expect_run(input logic [31:0] s, input logic [31:0] d, input int ubytes,
                            input int n, input bit si, input bit di);
    for (int i = 0; i < n; i++) begin
      wr_item_t e;
      e.addr = d + (di ? 32'(i * ubytes) : 32'd0);
      e.data = pat(s + (si ? 32'(i * ubytes) : 32'd0));
      exp_q.push_back(e);
    end
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    tick(); tick();
    while ((busy || rd_req || wr_req) && t < 5000) begin
      tick();
      t++;
    end
    if (t >= 5000) check(1'b0, req, "idle timeout", 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    join_none

    // R1: reset state
    repeat (3) tick();
    check(!rd_req && !wr_req && !busy && !done, "R1", "outputs in reset",
          {rd_req, wr_req, busy, done}, 0);
    rst_n = 1'b1;
    tick();
    check(!rd_req && !wr_req && !busy && !done, "R1", "outputs after reset",
          {rd_req, wr_req, busy, done}, 0);

    // T1: cycle stealing, sequential, 4-byte units, 4 units/operand, 48 bytes
    load(32'h0000_0200, 32'h0000_1000, 26'd48, 3'd2, 3'd2, 2'd1, 1'b0, 1'b1, 1'b1);
    check(unit_size == 3'd2, "R2", "unit size out", unit_size, 2);
    expect_run(32'h200, 32'h1000, 4, 12, 1'b1, 1'b1);
    n_wr = 0; last_wr = -1; min_gap = 1000; max_gap = 0;
    pulse_req();
    wait_idle("R3");
    check(n_wr == 4, "R3", "units in one operand", n_wr, 4);
    check(min_gap == 3 && max_gap == 3, "R8", "steal spacing", {min_gap, max_gap}, {32'd3, 32'd3});
    check(!done, "R5", "not done after one operand", done, 0);
    pulse_req();
    repeat (3) tick();
    check(busy, "R5", "busy mid operand", busy, 1);
    pulse_req();
    wait_idle("R5");
    check(n_wr == 12, "R5", "pending request served", n_wr, 12);
    check(done, "R11", "done at zero count", done, 1);
    check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);

    // T2: requests ignored after done, reload clears done
    begin
      bit quiet = 1'b1;
      pulse_req();
      for (int i = 0; i < 20; i++) begin
        if (rd_req || wr_req || !done) quiet = 1'b0;
        tick();
      end
      check(quiet, "R11", "quiet after done", quiet, 1);
    end
    load(32'h0, 32'h0, 26'd0, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1);
    tick();
    check(done, "R11", "zero load sets done", done, 1);
    load(32'h0000_0800, 32'h0000_3000, 26'd384, 3'd4, 3'd3, 2'd2, 1'b1, 1'b1, 1'b1);
    check(!done, "R11", "load clears done", done, 0);

    // T3: pipelined non-stop, 16-byte units, 8 units/operand, 24 units
    check(unit_size == 3'd4, "R2", "unit size out", unit_size, 4);
    expect_run(32'h800, 32'h3000, 16, 24, 1'b1, 1'b1);
    n_wr = 0; last_wr = -1; min_gap = 1000; max_gap = 0;
    pulse_req();
    wait_idle("R6");
    check(n_wr == 24, "R6", "one request moves all", n_wr, 24);
    check(min_gap == 1, "R9", "one unit per clock", min_gap, 1);
    check(max_gap <= 3, "R9", "operand turnaround", max_gap, 3);
    check(done, "R6", "done after non-stop", done, 1);

    // T4: unit mode, byte units, 2 units/operand, fixed source
    load(32'h0000_0300, 32'h0000_2000, 26'd8, 3'd0, 3'd1, 2'd0, 1'b0, 1'b0, 1'b1);
    expect_run(32'h300, 32'h2000, 1, 8, 1'b0, 1'b1);
    n_wr = 0;
    pulse_req();
    tick();
    pulse_req();
    wait_idle("R4");
    check(n_wr == 2, "R4", "request during operand dropped", n_wr, 2);
    check(!done, "R4", "not done", done, 0);
    for (int k = 0; k < 3; k++) begin
      pulse_req();
      wait_idle("R4");
    end
    check(n_wr == 8, "R10", "fixed source run", n_wr, 8);
    check(done, "R11", "done after unit runs", done, 1);

    // T5: pipelined sequential with random ready, fixed destination
    load(32'h0000_0900, 32'h0000_4000, 26'd128, 3'd3, 3'd3, 2'd1, 1'b1, 1'b1, 1'b0);
    expect_run(32'h900, 32'h4000, 8, 16, 1'b1, 1'b0);
    stall = 1'b1;
    n_wr = 0;
    pulse_req();
    wait_idle("R12");
    pulse_req();
    wait_idle("R12");
    stall = 1'b0;
    check(n_wr == 16, "R12", "writes under stalls", n_wr, 16);
    check(done, "R11", "done after stalled run", done, 1);
    check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule